// File: doc/BRIEF.md
# GPIO Pad Configuration Bank

This block holds the configuration of a 24-pin general-purpose I/O port and turns it into per-pin pad controls. A host reaches it over a simple byte-wide register interface. That interface has an 8-bit address, a write strobe with write data, and a read strobe whose data is registered and valid in the cycle after the strobe. The pins are packed eight to a byte: pin n is bit n mod 8 of byte n/8 in every register family.

Each pin has three configuration bits: a direction bit, a drive/bias kind bit and a pull bit. The kind bit has one meaning on outputs (push-pull or open-drain) and another on inputs (biased or unbiased). The output level sits in a latch that software never writes directly. Ones written to a set byte raise latch bits, and ones written to a clear byte lower them. Live pad levels can be read back. The upper eight pins form two optional groups of four. Each group is enabled by its own input, and a disabled pin is held fully off.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset every register bit is 0 and bus_rdata is 0x00, so every pin is an analog input: pad_oe, pad_out, pad_pu, pad_pd and pad_ie are all 0.
- R2: Pin n maps to bit n mod 8 of byte n/8. Direction bytes are at 0x60-0x62, kind bytes at 0x64-0x66 and pull bytes at 0x68-0x6A. Each of these can be written and reads back the value written.
- R3: A write to a set byte (0x6C-0x6E) raises each latch bit whose data bit is 1 and leaves the others unchanged. Reading a set byte returns the current latch byte.
- R4: A write to a clear byte (0x70-0x72) lowers each latch bit whose data bit is 1 and leaves the others unchanged. Reading a clear byte returns 0x00.
- R5: An available pin with direction 1 and kind 0 (push-pull output) has pad_oe=1, pad_out equal to its latch bit, pad_pu=0, pad_pd=0 and pad_ie=1.
- R6: An available pin with direction 1 and kind 1 (open-drain output) has pad_oe equal to the inverse of its latch bit, pad_out=0, pad_pu equal to its pull bit, pad_pd=0 and pad_ie=1.
- R7: An available pin with direction 0 and kind 1 (biased input) has pad_oe=0, pad_pu equal to the pull bit, pad_pd equal to its inverse and pad_ie=1.
- R8: An available pin with direction 0 and kind 0 is floating when pull is 1 (pad_ie=1, no pulls) and analog when pull is 0 (pad_ie=0, no pulls). In both cases pad_oe=0.
- R9: The state bytes at 0x10-0x12 return pad_in for each pin that is available and not analog, and 0 for all other pins. Writes to these addresses change nothing.
- R10: Pins 16-19 are available only while grp_lo_en=1, and pins 20-23 only while grp_hi_en=1. An unavailable pin drives pad_oe, pad_out, pad_pu, pad_pd and pad_ie to 0 whatever its configuration.
- R11: A read of an unmapped address returns 0x00, and a write to one changes no register. bus_rdata updates only on the clock edge that samples bus_rd=1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| grp_lo_en | input | 1 | Enables the pin group 16-19 |
| grp_hi_en | input | 1 | Enables the pin group 20-23 |
| pad_in | input | 24 | Live pad levels |
| pad_oe | output | 24 | Pad output enables |
| pad_out | output | 24 | Pad output values |
| pad_pu | output | 24 | Pull-up enables |
| pad_pd | output | 24 | Pull-down enables |
| pad_ie | output | 24 | Digital input enables |

## Verification
The bench gives every pin each of the eight configuration codes, with both latch levels and all four group-enable combinations, so that every byte lane and every pin position is covered. A design that swapped the meaning of the kind bit between inputs and outputs, or that drove the latch level onto an open-drain pad, would show the wrong pad vector on at least one pin. A whole-address-space read, made before and after stray writes to the state bytes and to unmapped addresses, exposes decode holes, off-by-one base addresses and set/clear logic that overwrites bits instead of masking them. State reads taken with disabled groups and analog pins catch a bank that leaks pad_in through a pin that should read 0.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        K_NONE,
        K_STATE,
        K_DIR,
        K_KIND,
        K_PULL,
        K_SET,
        K_CLR
    } reg_kind_e;

    localparam logic [7:0] BASE_STATE = 8'h10;
    localparam logic [7:0] BASE_DIR   = 8'h60;
    localparam logic [7:0] BASE_KIND  = 8'h64;
    localparam logic [7:0] BASE_PULL  = 8'h68;
    localparam logic [7:0] BASE_SET   = 8'h6C;
    localparam logic [7:0] BASE_CLR   = 8'h70;
endpackage

// File: rtl/pad_cfg_decode.sv
module pad_cfg_decode
    import pad_cfg_pkg::*;
#(
    parameter int NUM_BYTES = 3,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic [7:0]       addr,
    output reg_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    function automatic logic in_win(input logic [7:0] a, input logic [7:0] base);
        logic [8:0] lo;
        logic [8:0] hi;
        lo = {1'b0, base};
        hi = lo + 9'(NUM_BYTES);
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
    endfunction

    logic [7:0] offs;

    always_comb begin
        kind = K_NONE;
        offs = '0;
        if (in_win(addr, BASE_STATE)) begin
            kind = K_STATE;
            offs = addr - BASE_STATE;
        end else if (in_win(addr, BASE_DIR)) begin
            kind = K_DIR;
            offs = addr - BASE_DIR;
        end else if (in_win(addr, BASE_KIND)) begin
            kind = K_KIND;
            offs = addr - BASE_KIND;
        end else if (in_win(addr, BASE_PULL)) begin
            kind = K_PULL;
            offs = addr - BASE_PULL;
        end else if (in_win(addr, BASE_SET)) begin
            kind = K_SET;
            offs = addr - BASE_SET;
        end else if (in_win(addr, BASE_CLR)) begin
            kind = K_CLR;
            offs = addr - BASE_CLR;
        end
        idx = offs[IDX_W-1:0];
    end
endmodule

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
    import pad_cfg_pkg::*;
#(
    parameter int NUM_BYTES = 3,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int NPINS = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_kind_e         kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  kind_o,
    output logic [NPINS-1:0]  pull_o,
    output logic [NPINS-1:0]  lat_o
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] knd;
        logic [NPINS-1:0] pull;
        logic [NPINS-1:0] lat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    int   lane;

    always_comb begin
        cfg_d = cfg_q;
        lane  = int'(idx) * BYTE_W;
        if (wr && (int'(idx) < NUM_BYTES)) begin
            unique case (kind)
                K_DIR:  cfg_d.dir[lane +: BYTE_W]  = wdata;
                K_KIND: cfg_d.knd[lane +: BYTE_W]  = wdata;
                K_PULL: cfg_d.pull[lane +: BYTE_W] = wdata;
                K_SET:  cfg_d.lat[lane +: BYTE_W]  = cfg_q.lat[lane +: BYTE_W] | wdata;
                K_CLR:  cfg_d.lat[lane +: BYTE_W]  = cfg_q.lat[lane +: BYTE_W] & ~wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir_o  = cfg_q.dir;
    assign kind_o = cfg_q.knd;
    assign pull_o = cfg_q.pull;
    assign lat_o  = cfg_q.lat;

    logic [NPINS-1:0] wr_mask;
    assign wr_mask = NPINS'(wdata) << (int'(idx) * BYTE_W);

    // R3
    set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == K_SET) |=> ((cfg_q.lat & $past(wr_mask)) == $past(wr_mask)));

    // R4
    clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == K_CLR) |=> ((cfg_q.lat & $past(wr_mask)) == '0));

    // R9
    rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (kind == K_STATE || kind == K_NONE)) |=> $stable(cfg_q));
endmodule

// File: rtl/pad_cfg_pin.sv
module pad_cfg_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic avail,
    input  logic dir,
    input  logic knd,
    input  logic pull,
    input  logic lat,
    input  logic pin_in,
    output logic oe,
    output logic out,
    output logic pu,
    output logic pd,
    output logic ie,
    output logic state
);
    always_comb begin
        oe = 1'b0;
        out = 1'b0;
        pu = 1'b0;
        pd = 1'b0;
        ie = 1'b0;
        if (avail) begin
            unique case ({dir, knd})
                2'b10: begin
                    oe = 1'b1;
                    out = lat;
                    ie = 1'b1;
                end
                2'b11: begin
                    oe = ~lat;
                    pu = pull;
                    ie = 1'b1;
                end
                2'b01: begin
                    pu = pull;
                    pd = ~pull;
                    ie = 1'b1;
                end
                default: ie = pull;
            endcase
        end
        state = ie & pin_in;
    end

    // R10
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pu && pd));

    // R10
    grp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avail |-> !(oe || out || pu || pd || ie || state));

    // R6
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && dir && knd) |-> (!out && (oe != lat)));
endmodule

// File: rtl/pad_cfg_rdmux.sv
module pad_cfg_rdmux
    import pad_cfg_pkg::*;
#(
    parameter int NUM_BYTES = 3,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int NPINS = NUM_BYTES * BYTE_W
) (
    input  reg_kind_e         kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NPINS-1:0]  dir_v,
    input  logic [NPINS-1:0]  kind_v,
    input  logic [NPINS-1:0]  pull_v,
    input  logic [NPINS-1:0]  lat_v,
    input  logic [NPINS-1:0]  state_v,
    output logic [BYTE_W-1:0] rdata
);
    int lane;
    always_comb begin
        lane  = int'(idx) * BYTE_W;
        rdata = '0;
        if (int'(idx) < NUM_BYTES) begin
            unique case (kind)
                K_STATE: rdata = state_v[lane +: BYTE_W];
                K_DIR:   rdata = dir_v[lane +: BYTE_W];
                K_KIND:  rdata = kind_v[lane +: BYTE_W];
                K_PULL:  rdata = pull_v[lane +: BYTE_W];
                K_SET:   rdata = lat_v[lane +: BYTE_W];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
    import pad_cfg_pkg::*;
#(
    parameter int NUM_BYTES   = 3,
    parameter int ALWAYS_PINS = 16,
    parameter int GRP_PINS    = 4,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int NPINS = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              grp_lo_en,
    input  logic              grp_hi_en,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  pad_ie
);
    reg_kind_e        dec_kind;
    logic [IDX_W-1:0] dec_idx;
    logic [NPINS-1:0] dir_v, kind_v, pull_v, lat_v, state_v;
    logic [BYTE_W-1:0] rd_mux;

    pad_cfg_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
        .addr(bus_addr), .kind(dec_kind), .idx(dec_idx)
    );

    pad_cfg_regs #(.NUM_BYTES(NUM_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .kind(dec_kind), .idx(dec_idx),
        .wdata(bus_wdata), .dir_o(dir_v), .kind_o(kind_v), .pull_o(pull_v), .lat_o(lat_v)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        logic av;
        if (n < ALWAYS_PINS) begin : g_fix
            assign av = 1'b1;
        end else if (n < ALWAYS_PINS + GRP_PINS) begin : g_lo
            assign av = grp_lo_en;
        end else begin : g_hi
            assign av = grp_hi_en;
        end
        pad_cfg_pin u_pin (
            .clk(clk), .rst_n(rst_n), .avail(av),
            .dir(dir_v[n]), .knd(kind_v[n]), .pull(pull_v[n]), .lat(lat_v[n]),
            .pin_in(pad_in[n]),
            .oe(pad_oe[n]), .out(pad_out[n]), .pu(pad_pu[n]), .pd(pad_pd[n]),
            .ie(pad_ie[n]), .state(state_v[n])
        );
    end

    pad_cfg_rdmux #(.NUM_BYTES(NUM_BYTES)) u_rdmux (
        .kind(dec_kind), .idx(dec_idx), .dir_v(dir_v), .kind_v(kind_v),
        .pull_v(pull_v), .lat_v(lat_v), .state_v(state_v), .rdata(rd_mux)
    );

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec_kind == K_NONE) |=> (bus_rdata == '0));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    clr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec_kind == K_CLR) |=> (bus_rdata == '0));
endmodule

// File: tb/pad_cfg_bank_bench.sv
module pad_cfg_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        grp_lo_en = 1'b0;
    logic        grp_hi_en = 1'b0;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_oe, pad_out, pad_pu, pad_pd, pad_ie;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [23:0] m_dir = '0, m_knd = '0, m_pull = '0, m_lat = '0;

    pad_cfg_bank u_pad_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .grp_lo_en(grp_lo_en), .grp_hi_en(grp_hi_en), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_ie(pad_ie)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic avail_of(input int n);
        if (n < 16) return 1'b1;
        if (n < 20) return grp_lo_en;
        return grp_hi_en;
    endfunction

    // {oe,out,pu,pd,ie} per R5..R8, R10
    function automatic logic [4:0] exp_pad(input int n);
        logic d, k, p, l;
        d = m_dir[n]; k = m_knd[n]; p = m_pull[n]; l = m_lat[n];
        if (!avail_of(n)) return 5'b0;
        if (d && !k) return {1'b1, l, 1'b0, 1'b0, 1'b1};
        if (d && k)  return {~l, 1'b0, p, 1'b0, 1'b1};
        if (k)       return {1'b0, 1'b0, p, ~p, 1'b1};
        return {4'b0, p};
    endfunction

    function automatic logic [23:0] exp_state();
        logic [23:0] s;
        for (int n = 0; n < 24; n++)
            s[n] = pad_in[n] & avail_of(n) & (m_dir[n] | m_knd[n] | m_pull[n]);
        return s;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        logic [23:0] s;
        s = exp_state();
        if (a >= 8'h10 && a <= 8'h12) return s[(a - 8'h10) * 8 +: 8];
        if (a >= 8'h60 && a <= 8'h62) return m_dir[(a - 8'h60) * 8 +: 8];
        if (a >= 8'h64 && a <= 8'h66) return m_knd[(a - 8'h64) * 8 +: 8];
        if (a >= 8'h68 && a <= 8'h6A) return m_pull[(a - 8'h68) * 8 +: 8];
        if (a >= 8'h6C && a <= 8'h6E) return m_lat[(a - 8'h6C) * 8 +: 8];
        return 8'h00;
    endfunction

    task automatic check_pads();
        for (int n = 0; n < 24; n++) begin
            logic [4:0] e;
            e = exp_pad(n);
            if (n >= 16) check("R10 pad vector", {pad_oe[n], pad_out[n], pad_pu[n], pad_pd[n], pad_ie[n]}, e);
            else if (m_dir[n]) check(m_knd[n] ? "R6 pad vector" : "R5 pad vector",
                                     {pad_oe[n], pad_out[n], pad_pu[n], pad_pd[n], pad_ie[n]}, e);
            else check(m_knd[n] ? "R7 pad vector" : "R8 pad vector",
                       {pad_oe[n], pad_out[n], pad_pu[n], pad_pd[n], pad_ie[n]}, e);
        end
    endtask

    task automatic sweep_addr(input string req);
        logic [7:0] d;
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            check(req, d, exp_rd(8'(a)));
        end
    endtask

    task automatic write_cfg();
        for (int b = 0; b < 3; b++) begin
            wr(8'h60 + 8'(b), m_dir[b*8 +: 8]);
            wr(8'h64 + 8'(b), m_knd[b*8 +: 8]);
            wr(8'h68 + 8'(b), m_pull[b*8 +: 8]);
        end
    endtask

    task automatic write_lat();
        for (int b = 0; b < 3; b++) begin
            wr(8'h70 + 8'(b), 8'hFF);
            wr(8'h6C + 8'(b), m_lat[b*8 +: 8]);
        end
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 oe", pad_oe, 24'h0);
        check("R1 pulls", pad_pu | pad_pd, 24'h0);
        check("R1 ie", pad_ie, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        pad_in = 24'hFFFFFF;
        grp_lo_en = 1'b1; grp_hi_en = 1'b1;
        sweep_addr("R1 reset readback");

        // R5-R10 sweep over codes, latch levels and group enables
        for (int g = 0; g < 4; g++) begin
            grp_lo_en = g[0]; grp_hi_en = g[1];
            for (int k = 0; k < 8; k++) begin
                for (int n = 0; n < 24; n++) begin
                    int c;
                    c = (n + k) % 8;
                    m_dir[n] = c[2]; m_knd[n] = c[1]; m_pull[n] = c[0];
                end
                write_cfg();
                for (int p = 0; p < 2; p++) begin
                    for (int n = 0; n < 24; n++) m_lat[n] = 1'(((n >> 1) + p + k) & 1);
                    write_lat();
                    pad_in = 24'h5A3C96 ^ (24'(k * 37 + p * 11 + g) * 24'h010101);
                    @(negedge clk);
                    check_pads();
                    for (int b = 0; b < 3; b++) begin
                        rd(8'h10 + 8'(b), d);
                        check("R9 state byte", d, exp_rd(8'h10 + 8'(b)));
                    end
                end
            end
        end

        // R2 R3 R4 R11: full map readback with arbitrary contents
        grp_lo_en = 1'b1; grp_hi_en = 1'b0;
        m_dir = 24'hC3_5A_81; m_knd = 24'h0F_F0_66; m_pull = 24'h99_24_E7; m_lat = 24'h12_34_56;
        write_cfg();
        write_lat();
        pad_in = 24'hB7_E1_4D;
        sweep_addr("R2 map readback");

        // R3: set only raises ones
        wr(8'h6D, 8'h0F); m_lat[15:8] = m_lat[15:8] | 8'h0F;
        rd(8'h6D, d); check("R3 set merge", d, m_lat[15:8]);
        wr(8'h6E, 8'h00);
        rd(8'h6E, d); check("R3 set zeros", d, m_lat[23:16]);
        // R4: clear only lowers ones
        wr(8'h70, 8'hF0); m_lat[7:0] = m_lat[7:0] & 8'h0F;
        rd(8'h6C, d); check("R4 clear merge", d, m_lat[7:0]);
        rd(8'h70, d); check("R4 clear reads zero", d, 8'h00);
        @(negedge clk); check_pads();

        // R9 R11: stray writes change nothing
        wr(8'h10, 8'hFF); wr(8'h12, 8'h00); wr(8'h63, 8'hFF); wr(8'h6B, 8'hFF);
        wr(8'h73, 8'hFF); wr(8'h00, 8'hFF); wr(8'hFF, 8'hFF); wr(8'h5F, 8'hFF);
        sweep_addr("R11 after stray writes");

        // R11: rdata holds without read strobe
        rd(8'h64, hold);
        bus_addr = 8'h60;
        repeat (3) @(negedge clk);
        check("R11 rdata hold", bus_rdata, hold);

        // R10: disabled high group reads 0, outputs off
        grp_hi_en = 1'b0; pad_in = 24'hFFFFFF;
        @(negedge clk);
        rd(8'h12, d); check("R10 state gated", d, {m_dir[23:20] | m_knd[23:20] | m_pull[23:20], 4'h0} & 8'h00 | exp_rd(8'h12));
        check("R10 hi outputs off", {pad_oe[23:20], pad_pu[23:20], pad_pd[23:20], pad_ie[23:20]}, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule